// File: doc/BRIEF.md
# SD Data FIFO Byte Packer

This block sits between a host-visible 32-bit data FIFO and a byte-wide card data port. It is the data path of an SD host: a remaining byte count is loaded from a block-size register and a block-count strobe. The block then streams bytes, one per clock. In read mode it packs card bytes into FIFO words, little-endian. In write mode it unpacks FIFO words into bytes for the card, least-significant byte first. The FIFO is 16 entries deep by default.

The host reaches the FIFO through a data-register style pair of strobes, with a pop and a push, and both act in the cycle of the access. In read mode the packer owns the FIFO's write side and the host pops. In write mode the host pushes and the unpacker pops. With neither mode selected, the host owns both sides.

The block keeps three sticky status flags: data moved, data interrupt and block boundary. It drives an interrupt line from them. Two debug fields show the FIFO level and a two-state transfer mode.

Top module: `sd_fifo_packer`

## Requirements
- R1: The FIFO holds FIFO_DEPTH (16) words of 32 bits. A push while it is full is dropped, and the words already stored come out unchanged and in order.
- R2: A pop while the FIFO is empty returns 0 on `host_rdata` and leaves the level at 0. `host_rdata` always shows the head word combinationally.
- R3: A `bcount_wr` strobe loads `bytes_left` with `bcount_wdata` times the block size last written through `bsize_wr`. After reset `bytes_left` is 0.
- R4: In read mode the first card byte of a word lands in bits 7:0 and each later byte goes one lane higher. A word is pushed after 4 bytes. When the count reaches zero, a partial word is pushed early with its unused upper lanes zero.
- R5: In read mode a byte is taken (`card_rx_take`) only while `card_rx_valid` is high and the FIFO is not full. Otherwise the transfer pauses with `bytes_left` unchanged.
- R6: In write mode one byte is sent per clock (`card_tx_valid`), least-significant byte of each popped word first, and `bytes_left` drops by one per byte. With the FIFO empty and no bytes held, no byte is sent.
- R7: Each packer push in read mode and each unpacker pop in write mode sets `status_data`. It also sets `status_sdio` when `cfg_data_irq_en` is high.
- R8: In write mode `status_block` is set by the byte that leaves the remaining count at a nonzero multiple of the block size, or at zero. This happens only when `cfg_block_irq_en` is high and the block size is nonzero.
- R9: `dbg_mode` is 0 after reset and becomes 1 when a transferred byte brings `bytes_left` to zero.
- R10: `dbg_level` always equals the number of words in the FIFO.
- R11: The flags are sticky. A high bit of `status_clr` clears one flag in the next cycle: bit 0 clears data, bit 1 clears sdio and bit 2 clears block. `irq` is `status_sdio` OR `status_block`.
- R12: A host push or pop acts at the clock edge of the access, so the level changes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_read | input | 1 | Card-to-FIFO transfer mode (wins over write) |
| mode_write | input | 1 | FIFO-to-card transfer mode |
| cfg_data_irq_en | input | 1 | Enable the data interrupt flag |
| cfg_block_irq_en | input | 1 | Enable the block boundary flag |
| host_wr | input | 1 | Host push into the FIFO |
| host_wdata | input | WORD_W | Host push word |
| host_rd | input | 1 | Host pop from the FIFO |
| host_rdata | output | WORD_W | FIFO head word, 0 when empty |
| bsize_wr | input | 1 | Block size register write |
| bsize_wdata | input | BSIZE_W | Block size in bytes |
| bcount_wr | input | 1 | Block count write, loads the byte count |
| bcount_wdata | input | BCNT_W | Block count |
| card_rx_valid | input | 1 | Card has a byte ready |
| card_rx_byte | input | 8 | Card byte |
| card_rx_take | output | 1 | Card byte consumed this cycle |
| card_tx_valid | output | 1 | Byte sent to the card this cycle |
| card_tx_byte | output | 8 | Byte to the card |
| status_clr | input | 3 | Write-one-to-clear for {block, sdio, data} |
| status_data | output | 1 | Data moved flag |
| status_sdio | output | 1 | Data interrupt flag |
| status_block | output | 1 | Block boundary flag |
| irq | output | 1 | Interrupt request |
| bytes_left | output | BSIZE_W+BCNT_W | Remaining byte count |
| dbg_level | output | clog2(FIFO_DEPTH+1) | FIFO occupancy |
| dbg_mode | output | 4 | Transfer mode: 0 idle, 1 data complete |

## Verification
The assertions check the following on every cycle:
- the level never exceeds the depth;
- an empty FIFO reads as zero;
- a card byte is taken only when the card is ready and the FIFO has room;
- each sent byte lowers the count by one, and nothing moves at count zero;
- the final byte switches the debug mode;
- the data flag rises only after a byte movement.

Only the bench scenarios can show the data itself. This covers byte lane order in both directions, the zero-filled partial last word, the dropped seventeenth push, stall and resume at a full FIFO, and block flags falling exactly on block boundaries rather than mid-block.

// File: rtl/sdfp_pkg.sv
package sdfp_pkg;

   localparam int BYTE_W = 8;

   localparam logic [3:0] DBG_MODE_IDLE = 4'h0;
   localparam logic [3:0] DBG_MODE_DATA = 4'h1;

   // bit 0 data, bit 1 sdio, bit 2 block (matches status_clr)
   typedef struct packed {
      logic block;
      logic sdio;
      logic data;
   } sdfp_flags_t;

endpackage

// File: rtl/sdfp_fifo.sv
module sdfp_fifo #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WORD_W-1:0]          push_data,
   input  logic                       pop,
   output logic [WORD_W-1:0]          head,
   output logic [$clog2(DEPTH+1)-1:0] level,
   output logic                       full,
   output logic                       empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int LVL_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("sdfp_fifo: DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  rd_ptr, wr_ptr, rd_nxt, wr_nxt;
   logic [LVL_W-1:0]  lvl_q;
   logic              push_ok, pop_ok;

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign level   = lvl_q;
   assign head    = empty ? '0 : mem[rd_ptr];

   // pointer wrap: free for a power-of-two depth, compared otherwise
   if (DEPTH == (1 << PTR_W)) begin : g_wrap_pow2
      assign rd_nxt = rd_ptr + 1'b1;
      assign wr_nxt = wr_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         lvl_q  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   lvl_q <= lvl_q + 1'b1;
            2'b01:   lvl_q <= lvl_q - 1'b1;
            default: lvl_q <= lvl_q;
         endcase
      end
   end

endmodule

// File: rtl/sdfp_byte_engine.sv
module sdfp_byte_engine
   import sdfp_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int BSIZE_W = 10,
   parameter int BCNT_W  = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mode_rd,
   input  logic                       mode_wr,
   input  logic [BSIZE_W-1:0]         bsize,
   input  logic                       cnt_load,
   input  logic [BCNT_W-1:0]          cnt_value,
   input  logic                       fifo_full,
   input  logic                       fifo_empty,
   input  logic [WORD_W-1:0]          fifo_head,
   input  logic                       rx_valid,
   input  logic [BYTE_W-1:0]          rx_byte,
   output logic                       rx_take,
   output logic                       push,
   output logic [WORD_W-1:0]          push_data,
   output logic                       tx_valid,
   output logic [BYTE_W-1:0]          tx_byte,
   output logic                       pop,
   output logic [BSIZE_W+BCNT_W-1:0]  bytes_left,
   output logic                       blk_edge,
   output logic                       xfer_done
);
   localparam int CNT_W  = BSIZE_W + BCNT_W;
   localparam int LANES  = WORD_W / BYTE_W;
   localparam int LANE_W = $clog2(LANES);

   if ((WORD_W % BYTE_W) != 0 || LANES < 2) begin : g_bad_word
      $error("sdfp_byte_engine: WORD_W must be a multiple of 8, at least 16");
   end

   logic [CNT_W-1:0]   cnt_q;
   logic [BSIZE_W-1:0] blk_left_q;
   logic [LANE_W-1:0]  lane_q;
   logic [WORD_W-1:0]  acc_q, pack_word;
   logic [LANE_W-1:0]  held_q;
   logic [WORD_W-1:0]  sh_q;
   logic               active, last_byte, have_held, step;

   assign active    = (cnt_q != '0);
   assign last_byte = (cnt_q == CNT_W'(1));
   assign have_held = (held_q != '0);

   // ---------------- read side: pack bytes into a word ----------------
   assign rx_take = mode_rd && active && rx_valid && !fifo_full;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign pack_word[g*BYTE_W +: BYTE_W] =
         (lane_q == LANE_W'(g)) ? rx_byte : acc_q[g*BYTE_W +: BYTE_W];
   end

   assign push      = rx_take && ((lane_q == LANE_W'(LANES - 1)) || last_byte);
   assign push_data = pack_word;

   // ---------------- write side: unpack words into bytes --------------
   assign tx_valid = mode_wr && active && (have_held || !fifo_empty);
   assign pop      = mode_wr && active && !have_held && !fifo_empty;
   assign tx_byte  = have_held ? sh_q[BYTE_W-1:0] : fifo_head[BYTE_W-1:0];

   // ---------------- shared count and block tracking ------------------
   assign step      = rx_take || tx_valid;
   assign blk_edge  = tx_valid && (bsize != '0) && (blk_left_q == BSIZE_W'(1));
   assign xfer_done = step && last_byte;
   assign bytes_left = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         blk_left_q <= '0;
         lane_q     <= '0;
         acc_q      <= '0;
         held_q     <= '0;
         sh_q       <= '0;
      end else if (cnt_load) begin
         cnt_q      <= CNT_W'(bsize) * CNT_W'(cnt_value);
         blk_left_q <= bsize;
         lane_q     <= '0;
         acc_q      <= '0;
         held_q     <= '0;
         sh_q       <= '0;
      end else begin
         if (step) begin
            cnt_q <= cnt_q - 1'b1;
            if (blk_left_q <= BSIZE_W'(1)) blk_left_q <= bsize;
            else                           blk_left_q <= blk_left_q - 1'b1;
         end
         if (rx_take) begin
            if (push) begin
               lane_q <= '0;
               acc_q  <= '0;
            end else begin
               lane_q <= lane_q + 1'b1;
               acc_q  <= pack_word;
            end
         end
         if (pop) begin
            sh_q   <= fifo_head >> BYTE_W;
            held_q <= LANE_W'(LANES - 1);
         end else if (tx_valid && have_held) begin
            sh_q   <= sh_q >> BYTE_W;
            held_q <= held_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/sdfp_status.sv
module sdfp_status
   import sdfp_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        data_evt,
   input  logic        data_ie,
   input  logic        blk_edge,
   input  logic        block_ie,
   input  logic        xfer_done,
   input  logic [2:0]  clr,
   output sdfp_flags_t flags,
   output logic        irq,
   output logic [3:0]  dbg_mode
);
   sdfp_flags_t flags_q, set_v;

   always_comb begin
      set_v       = '0;
      set_v.data  = data_evt;
      set_v.sdio  = data_evt && data_ie;
      set_v.block = blk_edge && block_ie;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q  <= '0;
         dbg_mode <= DBG_MODE_IDLE;
      end else begin
         flags_q <= sdfp_flags_t'((flags_q & ~clr) | set_v);
         if (xfer_done) dbg_mode <= DBG_MODE_DATA;
      end
   end

   assign flags = flags_q;
   assign irq   = flags_q.sdio || flags_q.block;

endmodule

// File: rtl/sd_fifo_packer.sv
module sd_fifo_packer
   import sdfp_pkg::*;
#(
   parameter int WORD_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int BSIZE_W    = 10,
   parameter int BCNT_W     = 9
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            mode_read,
   input  logic                            mode_write,
   input  logic                            cfg_data_irq_en,
   input  logic                            cfg_block_irq_en,
   input  logic                            host_wr,
   input  logic [WORD_W-1:0]               host_wdata,
   input  logic                            host_rd,
   output logic [WORD_W-1:0]               host_rdata,
   input  logic                            bsize_wr,
   input  logic [BSIZE_W-1:0]              bsize_wdata,
   input  logic                            bcount_wr,
   input  logic [BCNT_W-1:0]               bcount_wdata,
   input  logic                            card_rx_valid,
   input  logic [7:0]                      card_rx_byte,
   output logic                            card_rx_take,
   output logic                            card_tx_valid,
   output logic [7:0]                      card_tx_byte,
   input  logic [2:0]                      status_clr,
   output logic                            status_data,
   output logic                            status_sdio,
   output logic                            status_block,
   output logic                            irq,
   output logic [BSIZE_W+BCNT_W-1:0]       bytes_left,
   output logic [$clog2(FIFO_DEPTH+1)-1:0] dbg_level,
   output logic [3:0]                      dbg_mode
);
   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   logic [BSIZE_W-1:0] bsize_q;
   logic               mode_rd, mode_wr;
   logic               eng_push, eng_pop, f_push, f_pop;
   logic [WORD_W-1:0]  eng_push_data, f_push_data, f_head;
   logic [LVL_W-1:0]   f_level;
   logic               f_full, f_empty, blk_edge, xfer_done;
   sdfp_flags_t        flags;

   assign mode_rd = mode_read;
   assign mode_wr = mode_write && !mode_read;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bsize_q <= '0;
      else if (bsize_wr) bsize_q <= bsize_wdata;
   end

   // FIFO side ownership follows the transfer direction
   assign f_push      = mode_rd ? eng_push      : host_wr;
   assign f_push_data = mode_rd ? eng_push_data : host_wdata;
   assign f_pop       = mode_wr ? eng_pop       : host_rd;

   sdfp_fifo #(
      .WORD_W (WORD_W),
      .DEPTH  (FIFO_DEPTH)
   ) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (f_push),
      .push_data (f_push_data),
      .pop       (f_pop),
      .head      (f_head),
      .level     (f_level),
      .full      (f_full),
      .empty     (f_empty)
   );

   sdfp_byte_engine #(
      .WORD_W  (WORD_W),
      .BSIZE_W (BSIZE_W),
      .BCNT_W  (BCNT_W)
   ) engine_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_rd    (mode_rd),
      .mode_wr    (mode_wr),
      .bsize      (bsize_q),
      .cnt_load   (bcount_wr),
      .cnt_value  (bcount_wdata),
      .fifo_full  (f_full),
      .fifo_empty (f_empty),
      .fifo_head  (f_head),
      .rx_valid   (card_rx_valid),
      .rx_byte    (card_rx_byte),
      .rx_take    (card_rx_take),
      .push       (eng_push),
      .push_data  (eng_push_data),
      .tx_valid   (card_tx_valid),
      .tx_byte    (card_tx_byte),
      .pop        (eng_pop),
      .bytes_left (bytes_left),
      .blk_edge   (blk_edge),
      .xfer_done  (xfer_done)
   );

   sdfp_status status_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .data_evt  (eng_push || eng_pop),
      .data_ie   (cfg_data_irq_en),
      .blk_edge  (blk_edge),
      .block_ie  (cfg_block_irq_en),
      .xfer_done (xfer_done),
      .clr       (status_clr),
      .flags     (flags),
      .irq       (irq),
      .dbg_mode  (dbg_mode)
   );

   assign host_rdata   = f_head;
   assign dbg_level    = f_level;
   assign status_data  = flags.data;
   assign status_sdio  = flags.sdio;
   assign status_block = flags.block;

endmodule

// File: rtl/sdfp_checker.sv
module sdfp_checker #(
   parameter int DEPTH  = 16,
   parameter int CNT_W  = 19,
   parameter int LVL_W  = 5,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [WORD_W-1:0] host_rdata,
   input logic              card_rx_valid,
   input logic              card_rx_take,
   input logic              card_tx_valid,
   input logic              bcount_wr,
   input logic [CNT_W-1:0]  bytes_left,
   input logic [LVL_W-1:0]  dbg_level,
   input logic [3:0]        dbg_mode,
   input logic              status_data
);
   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_level <= LVL_W'(DEPTH));

   // R2
   empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_level == '0) |-> (host_rdata == '0));

   // R5
   take_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      card_rx_take |-> (card_rx_valid && dbg_level != LVL_W'(DEPTH)));

   // R6
   byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_tx_valid && !bcount_wr) |=> (bytes_left == $past(bytes_left) - CNT_W'(1)));

   // R6
   idle_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bytes_left == '0) |-> (!card_tx_valid && !card_rx_take));

   // R9
   done_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((bytes_left == CNT_W'(1)) && (card_tx_valid || card_rx_take) && !bcount_wr)
      |=> (dbg_mode == 4'h1));

   // R7
   data_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status_data) |-> $past(card_rx_take || card_tx_valid));

endmodule

bind sd_fifo_packer sdfp_checker #(
   .DEPTH  (FIFO_DEPTH),
   .CNT_W  (BSIZE_W + BCNT_W),
   .LVL_W  ($clog2(FIFO_DEPTH + 1)),
   .WORD_W (WORD_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .host_rdata    (host_rdata),
   .card_rx_valid (card_rx_valid),
   .card_rx_take  (card_rx_take),
   .card_tx_valid (card_tx_valid),
   .bcount_wr     (bcount_wr),
   .bytes_left    (bytes_left),
   .dbg_level     (dbg_level),
   .dbg_mode      (dbg_mode),
   .status_data   (status_data)
);

// File: tb/sd_fifo_packer_tb_top.sv
module sd_fifo_packer_tb_top;
   localparam int WORD_W = 32;
   localparam int DEPTH  = 16;
   localparam int BSW    = 10;
   localparam int BCW    = 9;
   localparam int CNT_W  = BSW + BCW;
   localparam int LVL_W  = $clog2(DEPTH + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              mode_read = 1'b0, mode_write = 1'b0;
   logic              cfg_data_irq_en = 1'b0, cfg_block_irq_en = 1'b0;
   logic              host_wr = 1'b0, host_rd = 1'b0;
   logic [WORD_W-1:0] host_wdata = '0;
   logic [WORD_W-1:0] host_rdata;
   logic              bsize_wr = 1'b0, bcount_wr = 1'b0;
   logic [BSW-1:0]    bsize_wdata = '0;
   logic [BCW-1:0]    bcount_wdata = '0;
   logic              card_rx_valid = 1'b0;
   logic [7:0]        card_rx_byte;
   logic              card_rx_take, card_tx_valid;
   logic [7:0]        card_tx_byte;
   logic [2:0]        status_clr = '0;
   logic              status_data, status_sdio, status_block, irq;
   logic [CNT_W-1:0]  bytes_left;
   logic [LVL_W-1:0]  dbg_level;
   logic [3:0]        dbg_mode;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   logic [7:0]  exp_bytes[$];
   logic [31:0] exp_words[$];

   always #5 clk = ~clk;

   sd_fifo_packer dut_i (.*);

   // card source model: byte i of a run is (i+1)*0x11
   logic [7:0] rx_idx;
   logic       rx_restart = 1'b1;
   always @(posedge clk) begin
      if (rx_restart)        rx_idx <= 8'd0;
      else if (card_rx_take) rx_idx <= rx_idx + 8'd1;
   end
   assign card_rx_byte = 8'((int'(rx_idx) + 1) * 17);

   function automatic logic [31:0] pack(input int first, input int n);
      logic [31:0] w = '0;
      for (int i = 0; i < n; i++) w[i*8 +: 8] = 8'((first + i + 1) * 17);
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic push_word(input logic [31:0] w, input bit expect_tx);
      host_wr = 1'b1; host_wdata = w;
      if (expect_tx) for (int b = 0; b < 4; b++) exp_bytes.push_back(w[b*8 +: 8]);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic pop_word(input string tag);
      logic [31:0] e;
      host_rd = 1'b1;
      #1;
      e = (exp_words.size() != 0) ? exp_words.pop_front() : 32'h0;
      chk(host_rdata == e, tag, host_rdata, e);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic load(input int size, input int count);
      bsize_wr = 1'b1; bsize_wdata = BSW'(size);
      @(negedge clk);
      bsize_wr = 1'b0; bcount_wr = 1'b1; bcount_wdata = BCW'(count);
      @(negedge clk);
      bcount_wr = 1'b0;
   endtask

   task automatic clear_flags();
      status_clr = 3'b111;
      @(negedge clk);
      status_clr = 3'b000;
   endtask

   // scoreboard monitor for bytes sent to the card (R6 order)
   always begin
      @(negedge clk);
      #2;
      if (rst_n && card_tx_valid) begin
         if (exp_bytes.size() == 0) chk(1'b0, "R6 unexpected tx byte", card_tx_byte, 0);
         else begin
            logic [7:0] e;
            e = exp_bytes.pop_front();
            chk(card_tx_byte == e, "R6 tx byte order", card_tx_byte, e);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "watchdog", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      rx_restart = 1'b0;
      // reset state
      chk(bytes_left == 0, "R3 reset count", bytes_left, 0);
      chk(dbg_level == 0, "R10 reset level", dbg_level, 0);
      chk(dbg_mode == 0, "R9 reset mode", dbg_mode, 0);
      chk({status_block, status_sdio, status_data, irq} == 0, "R11 reset flags",
          {status_block, status_sdio, status_data, irq}, 0);

      // empty pop and host loopback
      pop_word("R2 empty pop");
      chk(dbg_level == 0, "R2 level after empty pop", dbg_level, 0);
      push_word(32'hCAFE0001, 1'b0);
      chk(dbg_level == 1, "R12 level after push", dbg_level, 1);
      push_word(32'hCAFE0002, 1'b0);
      exp_words.push_back(32'hCAFE0001);
      exp_words.push_back(32'hCAFE0002);
      pop_word("R12 host pop first");
      chk(dbg_level == 1, "R12 level after pop", dbg_level, 1);
      pop_word("R12 host pop second");

      // overflow: 17 pushes, 17th dropped
      for (int i = 0; i < 17; i++) push_word(32'h100 + i, 1'b0);
      chk(dbg_level == LVL_W'(DEPTH), "R1 level at full", dbg_level, DEPTH);
      for (int i = 0; i < 16; i++) exp_words.push_back(32'h100 + i);
      for (int i = 0; i < 16; i++) pop_word("R1 stored order");
      pop_word("R1 dropped word absent");

      // write mode: block size 8, two blocks
      mode_write = 1'b1; cfg_data_irq_en = 1'b1; cfg_block_irq_en = 1'b1;
      load(8, 2);
      chk(bytes_left == 16, "R3 loaded count", bytes_left, 16);
      cyc(3);
      chk(bytes_left == 16, "R6 underrun stall", bytes_left, 16);
      push_word(32'hA3A2A1A0, 1'b1);
      chk(dbg_level == 1, "R10 level one", dbg_level, 1);
      chk(bytes_left == 16, "R6 before first byte", bytes_left, 16);
      cyc(1);
      chk(bytes_left == 15, "R6 one byte per clock", bytes_left, 15);
      cyc(3);
      chk(bytes_left == 12, "R6 word sent", bytes_left, 12);
      chk(status_data && status_sdio, "R7 flags on pop", {status_data, status_sdio}, 2'b11);
      chk(!status_block, "R8 no flag mid-block", status_block, 0);
      push_word(32'hB3B2B1B0, 1'b1);
      cyc(6);
      chk(bytes_left == 8, "R6 second word", bytes_left, 8);
      chk(status_block, "R8 flag at boundary", status_block, 1);
      clear_flags();
      chk({status_block, status_sdio, status_data, irq} == 0, "R11 cleared",
          {status_block, status_sdio, status_data, irq}, 0);
      push_word(32'hC3C2C1C0, 1'b1);
      push_word(32'hD3D2D1D0, 1'b1);
      cyc(12);
      chk(bytes_left == 0, "R6 drained", bytes_left, 0);
      chk(dbg_level == 0, "R10 empty after drain", dbg_level, 0);
      chk(dbg_mode == 1, "R9 data mode", dbg_mode, 1);
      chk(status_block && irq, "R11 irq from block", {status_block, irq}, 2'b11);

      // write mode, enables off
      cfg_data_irq_en = 1'b0; cfg_block_irq_en = 1'b0;
      clear_flags();
      load(4, 1);
      push_word(32'h0F0E0D0C, 1'b1);
      cyc(8);
      chk(bytes_left == 0, "R6 short run", bytes_left, 0);
      chk(status_data && !status_sdio, "R7 sdio disabled", {status_data, status_sdio}, 2'b10);
      chk(!status_block && !irq, "R8 block disabled", {status_block, irq}, 0);

      // read mode: 6 bytes, partial last word
      mode_write = 1'b0; mode_read = 1'b1; cfg_data_irq_en = 1'b1;
      clear_flags();
      rx_restart = 1'b1; cyc(1); rx_restart = 1'b0;
      load(6, 1);
      cyc(5);
      chk(bytes_left == 6, "R5 card not ready", bytes_left, 6);
      card_rx_valid = 1'b1;
      cyc(10);
      chk(bytes_left == 0, "R4 read drained", bytes_left, 0);
      chk(dbg_level == 2, "R4 two words pushed", dbg_level, 2);
      chk(status_sdio && irq, "R7 read sdio", {status_sdio, irq}, 2'b11);
      exp_words.push_back(pack(0, 4));
      exp_words.push_back(pack(4, 2));
      pop_word("R4 full word lanes");
      pop_word("R4 partial word zero upper");

      // read mode: FIFO full pause and resume
      card_rx_valid = 1'b0;
      rx_restart = 1'b1; cyc(1); rx_restart = 1'b0;
      load(4, 17);
      card_rx_valid = 1'b1;
      cyc(80);
      chk(dbg_level == LVL_W'(DEPTH), "R5 full level", dbg_level, DEPTH);
      chk(bytes_left == 4, "R5 paused at full", bytes_left, 4);
      for (int k = 0; k < 17; k++) exp_words.push_back(pack(4 * k, 4));
      pop_word("R5 first after pause");
      cyc(8);
      chk(bytes_left == 0, "R5 resumed", bytes_left, 0);
      chk(dbg_level == LVL_W'(DEPTH), "R10 refilled", dbg_level, DEPTH);
      for (int k = 0; k < 16; k++) pop_word("R4 streamed words");
      chk(dbg_level == 0, "R10 final empty", dbg_level, 0);

      card_rx_valid = 1'b0; mode_read = 1'b0;
      cyc(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule